// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog built around a down-counter that moves one step for every pulse on a slow tick-enable input. In the intended system each tick stands for about 0.6 s, but the block does not depend on that value. Software programs an initial count, lets the counter run by clearing a halt bit, and keeps the system alive by writing the kick register. Any write to the kick register reloads the counter.

Escalation takes two steps. When the counter first expires, it reloads and sets a sticky timeout flag. It can also pulse an interrupt line. If software has not cleared that flag by the next expiry, a second-timeout flag is set. A one-cycle system-reset request then follows, unless a no-reboot inhibit bit is set. After a reset request the counter stays frozen until software has cleared the second-timeout flag and kicked again.

All registers sit on a simple synchronous bus. A write takes effect at the clock edge where the write enable is high. Read data is combinational from the address.

Top module: `wdog_twostage`

Register map, by word address:
- 0 holds the kick register. A write of any data reloads the counter. A read returns the live count.
- 1 holds the initial value, in the low CNT_W bits. Reads return 0 in the upper bits.
- 2 holds the first status register. Bit 3 is the timeout flag.
- 3 holds the second status register. Bit 1 is the second-timeout flag. Bit 2 is the boot flag.
- 4 holds the control register. Bit 11 is the halt bit. Bit 0 is the no-reboot inhibit bit. Every bit of this register is stored and read back.
- 5 holds the interrupt-enable register. Bit 13 is the interrupt enable.

## Requirements
- R1: Reset state:
  - the count and the initial value read 50;
  - control reads 0x0801, with halt=1 and no-reboot=1;
  - both status registers and the interrupt-enable register read 0;
  - irqPulse and resetReq are 0.
- R2: While halt (control bit 11) is 1, tick pulses leave the count unchanged.
- R3: When running, each tick decrements the count by one. A write to address 0 reloads the count with the initial value, and a read of address 0 returns the live count.
- R4: A write to address 1 stores the low CNT_W data bits as the initial value, and the upper bits read back as 0. A write whose field value is 0 to 3 is ignored, and the previous value stays.
- R5: A tick while the count is 0 is an expiry. The expiry reloads the count with the initial value, so each period lasts initial+1 ticks. If status-1 bit 3 is clear at that moment, the expiry sets it.
- R6: Status bits are write-1-to-clear: status-1 bit 3, status-2 bit 1 and status-2 bit 2. Writing 0 to a status bit leaves it unchanged.
- R7: A first expiry with interrupt enable (address 5 bit 13) at 1 gives exactly one one-cycle irqPulse. With the enable at 0, no pulse occurs. A second expiry never pulses irqPulse.
- R8: An expiry while status-1 bit 3 is still set sets status-2 bit 1. If no-reboot is 0, it also gives a one-cycle resetReq pulse and sets status-2 bit 2.
- R9: With no-reboot at 1, a second expiry still sets status-2 bit 1. It raises no resetReq and leaves status-2 bit 2 clear.
- R10: After a resetReq the counter ignores ticks. It resumes only after status-2 bit 1 is cleared and address 0 is then written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle count tick |
| regAddr | input | 3 | Register word address |
| regWe | input | 1 | Write enable |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for regAddr |
| irqPulse | output | 1 | One-cycle interrupt request on first expiry |
| resetReq | output | 1 | One-cycle system-reset request |

## Verification
The embedded properties assume that tickEn and regWe are clean synchronous levels. They also assume that regAddr is stable whenever regWe is high. The bench drives every input on the falling edge and samples outputs there too, so each tick or write lands on exactly one rising edge. Initial values are kept small (4 and 7) so that whole two-stage sequences fit in a short run. Illegal initial values are then tried explicitly, to show that the stored value is kept.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic load;
    logic run;
  } cntStrobe_t;
endpackage

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DEF_INIT = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  cntStrobe_t       strb,
  input  logic [CNT_W-1:0] initVal,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  assign expire = strb.run && tickEn && (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN)                    count <= CNT_W'(DEF_INIT);
    else if (strb.load || expire) count <= initVal;
    else if (strb.run && tickEn)  count <= count - 1'b1;
  end

  p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.load) |=> $stable(count));

  p_decrement_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && tickEn && !strb.load && count != '0) |=> (count == CNT_W'($past(count) - 1'b1)));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 10,
  parameter int DEF_INIT = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output cntStrobe_t        strb,
  output logic [CNT_W-1:0]  initVal,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqPulse,
  output logic              resetReq
);
  localparam int A_KICK = 0, A_INIT = 1, A_STS1 = 2, A_STS2 = 3, A_CTRL = 4, A_IRQ = 5;
  localparam int HALT_BIT = 11, NOREBOOT_BIT = 0, IRQEN_BIT = 13;
  localparam int TO_BIT = 3, SECOND_BIT = 1, BOOT_BIT = 2;
  localparam int MIN_INIT = 4;
  localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'((1 << HALT_BIT) | (1 << NOREBOOT_BIT));

  logic [DATA_W-1:0] ctrlReg;
  logic intEn, timeoutSts, secondTo, bootSts, stall;
  logic wrKick, wrInit, wrSts1, wrSts2, wrCtrl, wrIrq;
  logic firstExp, secondExp, fire, noReboot, halt;

  assign wrKick = regWe && (regAddr == ADDR_W'(A_KICK));
  assign wrInit = regWe && (regAddr == ADDR_W'(A_INIT));
  assign wrSts1 = regWe && (regAddr == ADDR_W'(A_STS1));
  assign wrSts2 = regWe && (regAddr == ADDR_W'(A_STS2));
  assign wrCtrl = regWe && (regAddr == ADDR_W'(A_CTRL));
  assign wrIrq  = regWe && (regAddr == ADDR_W'(A_IRQ));

  assign halt      = ctrlReg[HALT_BIT];
  assign noReboot  = ctrlReg[NOREBOOT_BIT];
  assign firstExp  = expire && !timeoutSts;
  assign secondExp = expire && timeoutSts;
  assign fire      = secondExp && !noReboot;

  assign strb.load = wrKick;
  assign strb.run  = !halt && !stall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg    <= CTRL_RST;
      initVal    <= CNT_W'(DEF_INIT);
      intEn      <= 1'b0;
      timeoutSts <= 1'b0;
      secondTo   <= 1'b0;
      bootSts    <= 1'b0;
      stall      <= 1'b0;
      irqPulse   <= 1'b0;
      resetReq   <= 1'b0;
    end else begin
      if (wrCtrl) ctrlReg <= regWdata;
      if (wrIrq)  intEn   <= regWdata[IRQEN_BIT];
      if (wrInit && regWdata[CNT_W-1:0] >= CNT_W'(MIN_INIT))
        initVal <= regWdata[CNT_W-1:0];

      if (firstExp)                         timeoutSts <= 1'b1;
      else if (wrSts1 && regWdata[TO_BIT])  timeoutSts <= 1'b0;

      if (secondExp)                            secondTo <= 1'b1;
      else if (wrSts2 && regWdata[SECOND_BIT])  secondTo <= 1'b0;

      if (fire)                               bootSts <= 1'b1;
      else if (wrSts2 && regWdata[BOOT_BIT])  bootSts <= 1'b0;

      if (fire)                       stall <= 1'b1;
      else if (wrKick && !secondTo)   stall <= 1'b0;

      irqPulse <= firstExp && intEn;
      resetReq <= fire;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_W'(A_KICK): regRdata = DATA_W'(count);
      ADDR_W'(A_INIT): regRdata = DATA_W'(initVal);
      ADDR_W'(A_STS1): regRdata[TO_BIT] = timeoutSts;
      ADDR_W'(A_STS2): begin
        regRdata[SECOND_BIT] = secondTo;
        regRdata[BOOT_BIT]   = bootSts;
      end
      ADDR_W'(A_CTRL): regRdata = ctrlReg;
      ADDR_W'(A_IRQ):  regRdata[IRQEN_BIT] = intEn;
      default:         regRdata = '0;
    endcase
  end

  p_init_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    initVal >= CNT_W'(MIN_INIT));

  p_irq_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> timeoutSts);

  p_irq_enabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(intEn));

  p_reset_second_r8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (secondTo && bootSts));

  p_reset_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !$past(noReboot));

  p_reset_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 10,
  parameter int DEF_INIT = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqPulse,
  output logic              resetReq
);
  cntStrobe_t       strb;
  logic [CNT_W-1:0] initVal;
  logic [CNT_W-1:0] count;
  logic             expire;

  wdog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DEF_INIT(DEF_INIT)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .count(count), .expire(expire), .strb(strb), .initVal(initVal),
    .regRdata(regRdata), .irqPulse(irqPulse), .resetReq(resetReq)
  );

  wdog_count #(.CNT_W(CNT_W), .DEF_INIT(DEF_INIT)) uCount (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb),
    .initVal(initVal), .count(count), .expire(expire)
  );
endmodule

// File: tb/tb_wdog_twostage.sv
module tb_wdog_twostage;
  logic clk = 0, rstN = 0, tickEn = 0, regWe = 0;
  logic [2:0] regAddr = 0;
  logic [15:0] regWdata = 0, regRdata;
  logic irqPulse, resetReq;
  int checks = 0, errors = 0, irqCnt = 0, rstCnt = 0;
  bit done = 0;

  wdog_twostage dut (.clk(clk), .rstN(rstN), .tickEn(tickEn), .regAddr(regAddr), .regWe(regWe),
                     .regWdata(regWdata), .regRdata(regRdata), .irqPulse(irqPulse), .resetReq(resetReq));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (irqPulse) irqCnt++;
    if (resetReq) rstCnt++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); regAddr = a; #1 v = int'(regRdata);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1;
      @(negedge clk); tickEn = 0;
    end
  endtask

  task automatic t_reset();
    int v;
    rd(0, v); chk("R1 count", v, 50);
    rd(1, v); chk("R1 init", v, 50);
    rd(2, v); chk("R1 sts1", v, 0);
    rd(3, v); chk("R1 sts2", v, 0);
    rd(4, v); chk("R1 ctrl", v, 'h0801);
    rd(5, v); chk("R1 irqen", v, 0);
    chk("R1 outputs", {irqPulse, resetReq}, 0);
  endtask

  task automatic t_halt();
    int v;
    tick(3); rd(0, v); chk("R2 halted count", v, 50);
  endtask

  task automatic t_init();
    int v;
    wr(1, 16'hFC07); rd(1, v); chk("R4 field write", v, 7);
    wr(1, 16'h0003); rd(1, v); chk("R4 value 3 ignored", v, 7);
    wr(1, 16'h0000); rd(1, v); chk("R4 value 0 ignored", v, 7);
    wr(1, 16'h0004); rd(1, v); chk("R4 value 4 taken", v, 4);
  endtask

  task automatic t_run();
    int v;
    wr(0, 16'h0); rd(0, v); chk("R3 kick reload", v, 4);
    wr(4, 16'h0000);                         // run, reboot allowed
    tick(2); rd(0, v); chk("R3 decrement", v, 2);
    wr(0, 16'h1234); rd(0, v); chk("R3 kick any data", v, 4);
  endtask

  task automatic t_first();
    int v;
    wr(5, 16'h2000); irqCnt = 0;
    tick(4); rd(0, v); chk("R5 count at zero", v, 0);
    rd(2, v); chk("R5 no flag yet", v, 0);
    tick(1); rd(0, v); chk("R5 reload on expiry", v, 4);
    rd(2, v); chk("R5 flag set", v, 8);
    chk("R7 irq pulse once", irqCnt, 1);
    wr(2, 16'h0000); rd(2, v); chk("R6 write 0 no effect", v, 8);
    wr(2, 16'h0008); rd(2, v); chk("R6 write 1 clears", v, 0);
    wr(5, 16'h0000); irqCnt = 0;
    tick(5); rd(2, v); chk("R5 flag again", v, 8);
    chk("R7 no irq when disabled", irqCnt, 0);
  endtask

  task automatic t_second();
    int v;
    wr(5, 16'h2000); irqCnt = 0; rstCnt = 0;
    tick(5); rd(3, v); chk("R8 second+boot set", v, 6);
    chk("R8 reset pulse once", rstCnt, 1);
    chk("R7 no irq on second expiry", irqCnt, 0);
    rd(0, v); chk("R8 reloaded", v, 4);
    tick(2); rd(0, v); chk("R10 stalled", v, 4);
    wr(0, 16'h0); tick(1); rd(0, v); chk("R10 kick before clear stays", v, 4);
    wr(3, 16'h0002); rd(3, v); chk("R6 clear second keeps boot", v, 4);
    wr(3, 16'h0004); rd(3, v); chk("R6 clear boot", v, 0);
    wr(2, 16'h0008);
    wr(0, 16'h0); tick(1); rd(0, v); chk("R10 resumes", v, 3);
  endtask

  task automatic t_inhibit();
    int v;
    wr(4, 16'h0001); wr(0, 16'h0); rstCnt = 0;
    tick(10); rd(3, v); chk("R9 second set, no boot", v, 2);
    chk("R9 no reset pulse", rstCnt, 0);
    tick(1); rd(0, v); chk("R9 no stall", v, 3);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run hung");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset(); t_halt(); t_init(); t_run(); t_first(); t_second(); t_inhibit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule